// File: doc/BRIEF.md
# Dual 8-bit Down-Counting Timer Pair

This block provides two independent 8-bit timers that count down and raise interrupt requests. They are deliberately unlike each other. The first timer counts ticks of a prescaled system clock, and a control bit picks one of two divide ratios. When it arrives at zero it raises its flag and then parks there. It does not run again until software writes a new count.

The second timer refills itself from a reload register each time it underflows, so it produces a periodic interrupt without software help. It counts either a fast internal tick or rising edges on an external event pin. That pin is synchronised inside the block before its edges are detected.

Software reaches both timers through a small write port and a combinational read port. The block holds the count values, the reload value, the run and source bits, and two sticky interrupt flags that are cleared by writing one to them. A count written while its timer is running is held back and takes effect on that timer's next tick. This keeps the divide phase intact.

Top module: `twin_down_timer`

## Requirements
- R1: After reset, both counts, the reload value, the control bits and both flags read as zero, and irqT0 and irqT1 are low.
- R2: Timer 0 counts down by one per tick while control bit 0 (run) is set. Control bit 1 selects the tick: 0 gives one tick every 4 clock cycles, 1 gives one tick every 1024 clock cycles.
- R3: When timer 0 counts from 1 to 0 it sets flag bit 0. It then stays at 0, without wrapping and without setting the flag again, until software writes a new count.
- R4: Timer 1, on a tick, loads the reload register and sets flag bit 1 if its count is 0; otherwise it decrements. A reload value N therefore gives one flag every N+1 ticks, and the count never wraps to all ones.
- R5: Control bit 3 selects the timer 1 source. With 0 the source is the 4-cycle internal tick. With 1 the source is rising edges of extEvent after a two-flop synchroniser, internal ticks are ignored, and a level held high counts only once.
- R6: A write to a count register while its timer is stopped loads the count before the next write can be observed. While the timer runs, the written value is held and replaces the decrement at that timer's next tick.
- R7: Flags are sticky. Writing 1 to bit 0 (timer 0) or bit 1 (timer 1) of the flag register clears that flag, and writing 0 leaves it unchanged. irqT0 and irqT1 follow flag bits 0 and 1.
- R8: Register addresses are 0 control, 1 timer 0 count, 2 timer 1 reload, 3 timer 1 count, 4 flags. The control bits are [0] timer 0 run, [1] timer 0 slow select, [2] timer 1 run, [3] timer 1 external select. Reads are combinational, and unimplemented bits read as zero.
- R9: A timer whose run bit is clear does not count, whatever its source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| extEvent | input | 1 | Asynchronous external event input for timer 1 |
| irqT0 | output | 1 | Timer 0 interrupt request |
| irqT1 | output | 1 | Timer 1 interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- Timer 0 changes only by a single step down from a nonzero value, or to the most recently written count.
- Timer 1 leaves zero only by taking the reload value or a written count.
- Each flag rises only together with its timer's zero condition.
- A flag never drops without a write-one clear.

Other behaviours depend on many cycles of timing and can only be shown by the directed scenarios. These are the two prescale ratios, a write being deferred to the next slow tick, and synchronised edges counting once per pulse while internal ticks are ignored. The scenarios also cover the register map and the idle behaviour of a stopped timer.

// File: rtl/twin_tmr_pkg.sv
package twin_tmr_pkg;

  localparam int ADDR_W = 3;
  localparam int CTRL_W = 4;

  // control bit positions
  localparam int C_T0_RUN  = 0;
  localparam int C_T0_SLOW = 1;
  localparam int C_T1_RUN  = 2;
  localparam int C_T1_EXT  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_T0CNT = 3'd1,
    REG_T1REL = 3'd2,
    REG_T1CNT = 3'd3,
    REG_FLAGS = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       t0Tick;
    logic       t1Tick;
    logic       t0Load;
    logic       t1Load;
    logic       relWr;
    logic [1:0] flagClr;
  } tmrStrobe_t;

endpackage

// File: rtl/twin_tmr_ctrl.sv
module twin_tmr_ctrl
  import twin_tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FAST_LOG2   = 2,
  parameter int SLOW_LOG2   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [CNT_W-1:0]          wrData,
  input  logic                      extEvent,
  output tmrStrobe_t                strobe,
  output logic [CTRL_W-1:0]         ctrlQ,
  output logic [CNT_W-1:0]          t0LoadVal,
  output logic [CNT_W-1:0]          t1LoadVal
);

  localparam int NUM_TMR = 2;

  // free-running prescaler
  logic [SLOW_LOG2-1:0] preQ;
  logic fastTick, slowTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else       preQ <= preQ + 1'b1;
  end

  assign fastTick = &preQ[FAST_LOG2-1:0];
  assign slowTick = &preQ;

  // external event synchroniser and rising-edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic extPrevQ, extRise;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extEvent;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extEvent};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrevQ <= 1'b0;
    else       extPrevQ <= syncQ[SYNC_STAGES-1];
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~extPrevQ;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (wrEn && wrAddr == REG_CTRL) ctrlQ <= wrData[CTRL_W-1:0];
  end

  // per-timer tick, run and write hit
  logic [NUM_TMR-1:0] run, tick, wrHit, loadGo;
  logic [CNT_W-1:0]   loadVal [NUM_TMR];

  assign run[0]   = ctrlQ[C_T0_RUN];
  assign run[1]   = ctrlQ[C_T1_RUN];
  assign tick[0]  = run[0] & (ctrlQ[C_T0_SLOW] ? slowTick : fastTick);
  assign tick[1]  = run[1] & (ctrlQ[C_T1_EXT] ? extRise : fastTick);
  assign wrHit[0] = wrEn && (wrAddr == REG_T0CNT);
  assign wrHit[1] = wrEn && (wrAddr == REG_T1CNT);

  // pending-load slot, one per timer
  generate
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_pend
      logic             pendQ;
      logic [CNT_W-1:0] pendData;

      assign loadGo[gi]  = pendQ & (~run[gi] | tick[gi]);
      assign loadVal[gi] = pendData;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pendQ    <= 1'b0;
          pendData <= '0;
        end else if (wrHit[gi]) begin
          pendQ    <= 1'b1;
          pendData <= wrData;
        end else if (loadGo[gi]) begin
          pendQ    <= 1'b0;
        end
      end
    end
  endgenerate

  assign t0LoadVal = loadVal[0];
  assign t1LoadVal = loadVal[1];

  always_comb begin
    strobe.t0Tick  = tick[0];
    strobe.t1Tick  = tick[1];
    strobe.t0Load  = loadGo[0];
    strobe.t1Load  = loadGo[1];
    strobe.relWr   = wrEn && (wrAddr == REG_T1REL);
    strobe.flagClr = (wrEn && wrAddr == REG_FLAGS) ? wrData[1:0] : 2'b00;
  end

endmodule

// File: rtl/twin_tmr_datapath.sv
module twin_tmr_datapath
  import twin_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strobe,
  input  logic [CNT_W-1:0]    t0LoadVal,
  input  logic [CNT_W-1:0]    t1LoadVal,
  input  logic [CNT_W-1:0]    wrData,
  input  logic [CTRL_W-1:0]   ctrlQ,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]    rdData,
  output logic [CNT_W-1:0]    cnt0Q,
  output logic [CNT_W-1:0]    cnt1Q,
  output logic [CNT_W-1:0]    relQ,
  output logic [1:0]          flagQ
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic t0Hit, t1Hit;

  assign t0Hit = !strobe.t0Load && strobe.t0Tick && (cnt0Q == ONE);
  assign t1Hit = !strobe.t1Load && strobe.t1Tick && (cnt1Q == '0);

  // timer 0: one-shot, parks at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             cnt0Q <= '0;
    else if (strobe.t0Load)                cnt0Q <= t0LoadVal;
    else if (strobe.t0Tick && cnt0Q != '0) cnt0Q <= cnt0Q - ONE;
  end

  // timer 1: auto-reload on underflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt1Q <= '0;
    else if (strobe.t1Load)     cnt1Q <= t1LoadVal;
    else if (strobe.t1Tick)     cnt1Q <= (cnt1Q == '0) ? relQ : cnt1Q - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             relQ <= '0;
    else if (strobe.relWr) relQ <= wrData;
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~strobe.flagClr) | {t1Hit, t0Hit};
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_CTRL:  rdData = CNT_W'(ctrlQ);
      REG_T0CNT: rdData = cnt0Q;
      REG_T1REL: rdData = relQ;
      REG_T1CNT: rdData = cnt1Q;
      REG_FLAGS: rdData = CNT_W'(flagQ);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import twin_tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FAST_LOG2   = 2,
  parameter int SLOW_LOG2   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [2:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              extEvent,
  output logic              irqT0,
  output logic              irqT1
);

  tmrStrobe_t          strobe;
  logic [CTRL_W-1:0]   ctrlQ;
  logic [CNT_W-1:0]    t0LoadVal, t1LoadVal;
  logic [CNT_W-1:0]    cnt0Q, cnt1Q, relQ;
  logic [1:0]          flagQ;

  twin_tmr_ctrl #(
    .CNT_W(CNT_W), .FAST_LOG2(FAST_LOG2),
    .SLOW_LOG2(SLOW_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extEvent(extEvent), .strobe(strobe), .ctrlQ(ctrlQ),
    .t0LoadVal(t0LoadVal), .t1LoadVal(t1LoadVal)
  );

  twin_tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .t0LoadVal(t0LoadVal), .t1LoadVal(t1LoadVal), .wrData(wrData),
    .ctrlQ(ctrlQ), .rdAddr(rdAddr), .rdData(rdData),
    .cnt0Q(cnt0Q), .cnt1Q(cnt1Q), .relQ(relQ), .flagQ(flagQ)
  );

  assign irqT0 = flagQ[0];
  assign irqT1 = flagQ[1];

endmodule

// File: rtl/twin_tmr_checker.sv
module twin_tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] relQ,
  input logic [1:0]       flags
);

  logic [CNT_W-1:0] lastWr0, lastWr1;
  logic             clr0, clr1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWr0 <= '0;
      lastWr1 <= '0;
    end else if (wrEn) begin
      if (wrAddr == 3'd1) lastWr0 <= wrData;
      if (wrAddr == 3'd3) lastWr1 <= wrData;
    end
  end

  assign clr0 = wrEn && (wrAddr == 3'd4) && wrData[0];
  assign clr1 = wrEn && (wrAddr == 3'd4) && wrData[1];

  // R3: timer 0 only steps down from nonzero or takes a written count
  p_t0_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt0 != $past(cnt0)) |->
      ((cnt0 == $past(cnt0) - 1'b1 && $past(cnt0) != '0) || cnt0 == lastWr0));

  // R3: timer 0 flag rises only as its count reaches zero
  p_t0_flag_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> (cnt0 == '0));

  // R4: timer 1 leaves zero only via reload or a written count
  p_t1_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cnt1) == '0 && cnt1 != '0) |-> (cnt1 == $past(relQ) || cnt1 == lastWr1));

  // R4: timer 1 flag rises only on underflow from zero
  p_t1_flag_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> ($past(cnt1) == '0));

  // R7: flags stay set until cleared by a write of one
  p_flag0_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !clr0) |=> flags[0]);

  p_flag1_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !clr1) |=> flags[1]);

endmodule

bind twin_down_timer twin_tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cnt0(cnt0Q), .cnt1(cnt1Q), .relQ(relQ), .flags(flagQ)
);

// File: tb/twin_down_timer_test.sv
`timescale 1ns/1ps
module twin_down_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       extEvent = 1'b0;
  logic       irqT0, irqT1;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  twin_down_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extEvent(extEvent),
    .irqT0(irqT0), .irqT1(irqT1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic extPulse();
    @(negedge clk); extEvent = 1'b1;
    waitCyc(10);
    extEvent = 1'b0;
    waitCyc(6);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(irqT0 == 0 && irqT1 == 0, "R1 irqs low", {irqT1, irqT0}, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(3'd0, 8'hFA);
    rd(3'd0, v);
    check(v == 8'h0A, "R8 ctrl readback masks unused bits", v, 8'h0A);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h5C);
    rd(3'd2, v);
    check(v == 8'h5C, "R8 reload readback", v, 8'h5C);
    rd(3'd6, v);
    check(v == 0, "R8 unmapped address reads zero", v, 0);
  endtask

  task automatic t_t0_fast();
    logic [7:0] v;
    wr(3'd1, 8'd10);
    waitCyc(1);
    rd(3'd1, v);
    check(v == 10, "R6 stopped load immediate", v, 10);
    waitCyc(40);
    rd(3'd1, v);
    check(v == 10, "R9 stopped timer0 holds", v, 10);
    wr(3'd0, 8'h01);
    waitCyc(20);
    rd(3'd1, v);
    check(v >= 4 && v <= 6, "R2 fast rate one per 4 cycles", v, 5);
    check(irqT0 == 0, "R3 no flag before zero", irqT0, 0);
    waitCyc(40);
    rd(3'd1, v);
    check(v == 0, "R3 reached zero", v, 0);
    check(irqT0 == 1, "R3 flag set at zero", irqT0, 1);
    waitCyc(100);
    rd(3'd1, v);
    check(v == 0, "R3 parks at zero, no wrap", v, 0);
    wr(3'd4, 8'h00);
    check(irqT0 == 1, "R7 write zero keeps flag", irqT0, 1);
    wr(3'd4, 8'h01);
    check(irqT0 == 0, "R7 write one clears flag", irqT0, 0);
    waitCyc(50);
    rd(3'd1, v);
    check(irqT0 == 0 && v == 0, "R3 no restart without write", {irqT0, v}, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_t0_slow();
    logic [7:0] v;
    int guard;
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h03);
    waitCyc(100);
    rd(3'd1, v);
    check(v == 2, "R2 slow select does not tick at 4", v, 2);
    guard = 0;
    v = 2;
    while (v == 2 && guard < 1200) begin
      rd(3'd1, v);
      guard++;
    end
    check(v == 1, "R2 slow tick decrements", v, 1);
    wr(3'd1, 8'd7);
    waitCyc(5);
    rd(3'd1, v);
    check(v == 1, "R6 running write deferred", v, 1);
    waitCyc(1100);
    rd(3'd1, v);
    check(v == 7, "R6 deferred write applied at tick", v, 7);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h03);
  endtask

  task automatic t_t1_internal();
    logic [7:0] v;
    int maxV;
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd3);
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h04);
    waitCyc(24);
    check(irqT1 == 1, "R4 underflow sets flag", irqT1, 1);
    maxV = 0;
    for (int i = 0; i < 40; i++) begin
      rd(3'd3, v);
      if (v > maxV) maxV = v;
    end
    check(maxV <= 3, "R4 reloads, never wraps", maxV, 3);
    wr(3'd4, 8'h02);
    check(irqT1 == 0, "R7 clear timer1 flag", irqT1, 0);
    waitCyc(20);
    check(irqT1 == 1, "R4 periodic reload repeats", irqT1, 1);
    check(irqT0 == 0, "R7 timer0 flag untouched", irqT0, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_t1_ext();
    logic [7:0] v;
    wr(3'd2, 8'd2);
    wr(3'd3, 8'd2);
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h0C);
    waitCyc(60);
    rd(3'd3, v);
    check(v == 2, "R5 internal ticks ignored in ext mode", v, 2);
    extPulse();
    rd(3'd3, v);
    check(v == 1, "R5 long pulse counts once", v, 1);
    extPulse();
    rd(3'd3, v);
    check(v == 0, "R5 second edge", v, 0);
    check(irqT1 == 0, "R4 no flag before underflow", irqT1, 0);
    extPulse();
    rd(3'd3, v);
    check(v == 2 && irqT1 == 1, "R4 ext underflow reloads and flags", v, 2);
    wr(3'd0, 8'h08);
    extPulse();
    rd(3'd3, v);
    check(v == 2, "R9 stopped timer1 ignores edges", v, 2);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    t_reset();
    t_regmap();
    t_t0_fast();
    t_t0_slow();
    t_t1_internal();
    t_t1_ext();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule